// File: doc/BRIEF.md
# Hardware Breakpoint Address Matcher

This block watches each memory or instruction access of a processor core and compares it with four programmable breakpoint slots. Each slot holds a linear address. A shared 32-bit control word gives each slot a pair of enable bits, a 2-bit access-type code and a 2-bit length code. Every access brings a start address, a byte count and two access-type codes that the access satisfies. A slot matches when one of those codes equals its type field and when the access byte range overlaps the slot's aligned window.

The block reports a hit only when at least one enabled slot matches. When a hit occurs, the reported four-bit mask has a bit for every slot that matched, including slots that are not enabled. Hits go into a sticky status register that software clears through the write port. When the core marks the current boundary as inhibited, a hit is held as pending. The next uninhibited access commits it to status and raises a trap pulse. Without inhibition, status is updated at once and a fault pulse is raised.

Top module: `bkpt_matcher`

## Requirements
- R1: After reset, `hit`, `hit_mask`, `status`, `exc_fault` and `exc_trap` are all zero, and the control word and the four slot addresses are zero.
- R2: Slot n counts as enabled when either control bit 2n or control bit 2n+1 is set. No hit is reported while control bits 7:0 are all zero.
- R3: Slot n's type field is control bits 17+4n:16+4n. The slot matches only if this field equals `acc_type_a` or `acc_type_b`.
- R4: Slot n's length code is control bits 19+4n:18+4n. Code 01 clears address bit 0, code 11 clears bits 1:0, and codes 00 and 10 apply no masking. The window ends at the aligned address plus the code value, so code 10 spans three bytes.
- R5: The access covers `acc_addr` to `acc_addr + acc_size - 1`, computed modulo 2^AW. A window overlaps when the access start is at most the window end and the access end is at least the window start.
- R6: A hit is reported only when an enabled slot matches. On a hit, mask bit n is set for every matching slot n, whether or not that slot is enabled. Without a hit, the mask is zero.
- R7: `hit` and `hit_mask` show the result of an access one clock after the cycle in which `acc_valid` is high. They are zero after any cycle without `acc_valid`.
- R8: On an access with `dbg_inhibit` low, the new mask is ORed into `status`, never clearing a bit, and `exc_fault` pulses in the same cycle as `hit`.
- R9: On an access with `dbg_inhibit` high, a hit leaves `status` unchanged, raises no exception and is held pending. The next access with `dbg_inhibit` low ORs the pending bits into `status` and pulses `exc_trap`.
- R10: A write on the register port with index 0 to 3 loads that slot's address, index 4 loads the control word, and index 5 overwrites `status` with `cfg_wdata[3:0]`. In the same clock, any bits committed by an access are ORed on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index (0-3 slot address, 4 control, 5 status) |
| cfg_wdata | input | AW | Write data |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | AW | Linear start address of the access |
| acc_size | input | 4 | Access size in bytes (1 to 15) |
| acc_type_a | input | 2 | First acceptable access-type code |
| acc_type_b | input | 2 | Second acceptable access-type code |
| dbg_inhibit | input | 1 | Debug events inhibited at this boundary |
| hit | output | 1 | Registered hit flag |
| hit_mask | output | 4 | Registered per-slot match mask |
| status | output | 4 | Sticky status bits |
| exc_fault | output | 1 | Immediate debug exception pulse |
| exc_trap | output | 1 | Deferred debug exception pulse |

## Verification
A wrong length decode or a wrong alignment shows up as a missing or extra mask bit on the access that touches a window edge, and it appears at the ports one clock after the strobe. A corrupted pending register stays hidden while the boundary is inhibited. It surfaces only on the next uninhibited access, as a wrong `exc_trap` or wrong `status` bits one clock later, so the deferral tests check both sides of that access. A lost sticky bit shows on the very next status sample. For that reason, status is checked after every step of an accumulation sequence.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int CTL_W     = 32;
  localparam int IDX_W     = 3;
  localparam int SIZE_W    = 4;

  localparam logic [IDX_W-1:0] IDX_CTL    = 3'd4;
  localparam logic [IDX_W-1:0] IDX_STATUS = 3'd5;

  typedef enum logic [1:0] {
    LEN_ONE   = 2'b00,
    LEN_TWO   = 2'b01,
    LEN_ODD   = 2'b10,
    LEN_FOUR  = 2'b11
  } len_code_e;

  function automatic int en_lsb(input int slot);
    return 2 * slot;
  endfunction

  function automatic int type_lsb(input int slot);
    return 16 + 4 * slot;
  endfunction

  function automatic int len_lsb(input int slot);
    return 18 + 4 * slot;
  endfunction
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [AW-1:0]           wr_data,
  output logic [NUM_SLOTS*AW-1:0] slot_addr,
  output logic [CTL_W-1:0]        ctl_word,
  output logic                    status_wr,
  output logic [NUM_SLOTS-1:0]    status_wdata
);
  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_addr
    logic [AW-1:0] addr_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        addr_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(n))
        addr_q <= wr_data;
    end
    assign slot_addr[n*AW +: AW] = addr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_word <= '0;
    else if (wr_en && wr_idx == IDX_CTL)
      ctl_word <= wr_data[CTL_W-1:0];
  end

  assign status_wr    = wr_en && (wr_idx == IDX_STATUS);
  assign status_wdata = wr_data[NUM_SLOTS-1:0];
endmodule

// File: rtl/bkpt_slot.sv
module bkpt_slot
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] bp_addr,
  input  logic [1:0]    en_pair,
  input  logic [1:0]    type_fld,
  input  logic [1:0]    len_fld,
  input  logic [AW-1:0] acc_start,
  input  logic [AW-1:0] acc_last,
  input  logic [1:0]    type_a,
  input  logic [1:0]    type_b,
  output logic          slot_en,
  output logic          slot_match
);
  function automatic logic [AW-1:0] align_base(input logic [AW-1:0] a,
                                               input logic [1:0] code);
    logic [AW-1:0] m;
    case (len_code_e'(code))
      LEN_TWO:  m = AW'(1);
      LEN_FOUR: m = AW'(3);
      default:  m = '0;
    endcase
    return a & ~m;
  endfunction

  function automatic logic [AW-1:0] win_end(input logic [AW-1:0] base,
                                            input logic [1:0] code);
    return base + AW'(code);
  endfunction

  logic [AW-1:0] lo, hi;
  logic          type_ok, overlap;

  assign lo         = align_base(bp_addr, len_fld);
  assign hi         = win_end(lo, len_fld);
  assign type_ok    = (type_fld == type_a) || (type_fld == type_b);
  assign overlap    = (acc_start <= hi) && (acc_last >= lo);
  assign slot_en    = |en_pair;
  assign slot_match = type_ok && overlap;
endmodule

// File: rtl/bkpt_accum.sv
module bkpt_accum
  import bkpt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 inhibit,
  input  logic                 hit_now,
  input  logic [NUM_SLOTS-1:0] mask_now,
  input  logic                 status_wr,
  input  logic [NUM_SLOTS-1:0] status_wdata,
  output logic                 hit,
  output logic [NUM_SLOTS-1:0] hit_mask,
  output logic [NUM_SLOTS-1:0] status,
  output logic                 exc_fault,
  output logic                 exc_trap
);
  logic [NUM_SLOTS-1:0] pend_mask;
  logic                 pend_flag;
  logic                 commit_now;
  logic [NUM_SLOTS-1:0] commit_bits, status_base;

  assign commit_now  = acc_valid && !inhibit;
  assign commit_bits = commit_now ? (pend_mask | mask_now) : '0;
  assign status_base = status_wr ? status_wdata : status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit       <= 1'b0;
      hit_mask  <= '0;
      status    <= '0;
      exc_fault <= 1'b0;
      exc_trap  <= 1'b0;
      pend_mask <= '0;
      pend_flag <= 1'b0;
    end else begin
      hit       <= acc_valid && hit_now;
      hit_mask  <= acc_valid ? mask_now : '0;
      status    <= status_base | commit_bits;
      exc_fault <= commit_now && hit_now;
      exc_trap  <= commit_now && pend_flag;
      if (acc_valid && inhibit) begin
        pend_mask <= pend_mask | mask_now;
        pend_flag <= pend_flag | hit_now;
      end else if (commit_now) begin
        pend_mask <= '0;
        pend_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bkpt_matcher.sv
module bkpt_matcher
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [AW-1:0]        cfg_wdata,
  input  logic                 acc_valid,
  input  logic [AW-1:0]        acc_addr,
  input  logic [SIZE_W-1:0]    acc_size,
  input  logic [1:0]           acc_type_a,
  input  logic [1:0]           acc_type_b,
  input  logic                 dbg_inhibit,
  output logic                 hit,
  output logic [NUM_SLOTS-1:0] hit_mask,
  output logic [NUM_SLOTS-1:0] status,
  output logic                 exc_fault,
  output logic                 exc_trap
);
  function automatic logic [AW-1:0] access_last(input logic [AW-1:0] a,
                                                input logic [SIZE_W-1:0] sz);
    return a + AW'(sz) - AW'(1);
  endfunction

  logic [NUM_SLOTS*AW-1:0] slot_addr;
  logic [CTL_W-1:0]        ctl_word;
  logic                    status_wr;
  logic [NUM_SLOTS-1:0]    status_wdata;
  logic [NUM_SLOTS-1:0]    slot_en, slot_match;
  logic [AW-1:0]           acc_last;
  logic                    any_enable, hit_now;
  logic [NUM_SLOTS-1:0]    mask_now;

  bkpt_regs #(.AW(AW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_we),
    .wr_idx       (cfg_idx),
    .wr_data      (cfg_wdata),
    .slot_addr    (slot_addr),
    .ctl_word     (ctl_word),
    .status_wr    (status_wr),
    .status_wdata (status_wdata)
  );

  assign acc_last = access_last(acc_addr, acc_size);

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    bkpt_slot #(.AW(AW)) u_slot (
      .bp_addr    (slot_addr[n*AW +: AW]),
      .en_pair    (ctl_word[en_lsb(n) +: 2]),
      .type_fld   (ctl_word[type_lsb(n) +: 2]),
      .len_fld    (ctl_word[len_lsb(n) +: 2]),
      .acc_start  (acc_addr),
      .acc_last   (acc_last),
      .type_a     (acc_type_a),
      .type_b     (acc_type_b),
      .slot_en    (slot_en[n]),
      .slot_match (slot_match[n])
    );
  end

  assign any_enable = |ctl_word[2*NUM_SLOTS-1:0];
  assign hit_now    = any_enable && |(slot_en & slot_match);
  assign mask_now   = hit_now ? slot_match : '0;

  bkpt_accum u_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .inhibit      (dbg_inhibit),
    .hit_now      (hit_now),
    .mask_now     (mask_now),
    .status_wr    (status_wr),
    .status_wdata (status_wdata),
    .hit          (hit),
    .hit_mask     (hit_mask),
    .status       (status),
    .exc_fault    (exc_fault),
    .exc_trap     (exc_trap)
  );
endmodule

// File: rtl/bkpt_matcher_chk.sv
module bkpt_matcher_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       dbg_inhibit,
  input logic       hit,
  input logic [3:0] hit_mask,
  input logic [3:0] status,
  input logic       exc_fault,
  input logic       exc_trap,
  input logic [7:0] en_bits,
  input logic       status_wr
);
  a_r6_hit_has_mask: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_mask != 4'b0);

  a_r6_mask_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> hit_mask == 4'b0);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !hit);

  a_r2_no_enable_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && en_bits == 8'h00) |=> !hit);

  a_r8_fault_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fault |-> hit);

  a_r8_status_covers: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fault |-> (status & hit_mask) == hit_mask);

  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !status_wr |=> (status & $past(status)) == $past(status));

  a_r9_inhibit_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && dbg_inhibit) |=> (!exc_fault && !exc_trap));

  a_r9_trap_commits: assert property (@(posedge clk) disable iff (!rst_n)
    exc_trap |-> status != 4'b0);
endmodule

bind bkpt_matcher bkpt_matcher_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .dbg_inhibit (dbg_inhibit),
  .hit         (hit),
  .hit_mask    (hit_mask),
  .status      (status),
  .exc_fault   (exc_fault),
  .exc_trap    (exc_trap),
  .en_bits     (ctl_word[7:0]),
  .status_wr   (status_wr)
);

// File: tb/bkpt_matcher_test.sv
module bkpt_matcher_test;
  localparam int AW = 32;

  typedef struct packed {
    logic [31:0] ctl;
    logic [31:0] addr;
    logic [3:0]  size;
    logic [1:0]  ta;
    logic [1:0]  tb;
    logic        ehit;
    logic [3:0]  emask;
  } vec_t;

  // slot addresses: 0x1000, 0x1002, 0x3005, 0x4007
  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{32'h00000001, 32'h00001000, 4'd1,  2'd0, 2'd0, 1'b1, 4'h1}, // R5 exact byte
    '{32'h00000001, 32'h00001001, 4'd1,  2'd0, 2'd0, 1'b0, 4'h0}, // R5 past end
    '{32'h00000001, 32'h00001002, 4'd1,  2'd0, 2'd0, 1'b0, 4'h0}, // R6 disabled alone
    '{32'h00000001, 32'h00000FFF, 4'd4,  2'd0, 2'd0, 1'b1, 4'h3}, // R6 disabled reported
    '{32'h0C000020, 32'h00003007, 4'd1,  2'd0, 2'd0, 1'b1, 4'h4}, // R4 len 11, R2 upper bit
    '{32'h0C000020, 32'h00003008, 4'd1,  2'd0, 2'd0, 1'b0, 4'h0}, // R4 above window
    '{32'h0C000020, 32'h00003003, 4'd1,  2'd0, 2'd0, 1'b0, 4'h0}, // R4 below aligned base
    '{32'h500000C0, 32'h00004006, 4'd1,  2'd1, 2'd3, 1'b1, 4'h8}, // R4 len 01, R3 code a
    '{32'h500000C0, 32'h00004006, 4'd1,  2'd0, 2'd2, 1'b0, 4'h0}, // R3 no code
    '{32'h500000C0, 32'h00004006, 4'd1,  2'd2, 2'd1, 1'b1, 4'h8}, // R3 code b
    '{32'h00080002, 32'h00001002, 4'd1,  2'd0, 2'd0, 1'b1, 4'h3}, // R4 len 10 spans +2
    '{32'h00080002, 32'h00001003, 4'd1,  2'd0, 2'd0, 1'b0, 4'h0}, // R4 len 10 end
    '{32'h00000000, 32'h00001000, 4'd1,  2'd0, 2'd0, 1'b0, 4'h0}, // R2 all disabled
    '{32'h000000FF, 32'h00000FF0, 4'd15, 2'd0, 2'd0, 1'b0, 4'h0}, // R5 ends short
    '{32'h000000FF, 32'h00001000, 4'd8,  2'd0, 2'd0, 1'b1, 4'h3}  // R5 multi-slot
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [3:0]    acc_size = 4'd1;
  logic [1:0]    acc_type_a = '0;
  logic [1:0]    acc_type_b = '0;
  logic          dbg_inhibit = 1'b0;
  logic          hit, exc_fault, exc_trap;
  logic [3:0]    hit_mask, status;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bkpt_matcher #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_type_a(acc_type_a), .acc_type_b(acc_type_b),
    .dbg_inhibit(dbg_inhibit), .hit(hit), .hit_mask(hit_mask),
    .status(status), .exc_fault(exc_fault), .exc_trap(exc_trap)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one access strobe, then sample at the following negedge
  task automatic access(input logic [31:0] a, input logic [3:0] sz,
                        input logic [1:0] ta, input logic [1:0] tb, input logic inh);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz;
    acc_type_a = ta; acc_type_b = tb; dbg_inhibit = inh;
    @(negedge clk);
    acc_valid = 1'b0; dbg_inhibit = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 hit", 32'(hit), 0);
    check("R1 hit_mask", 32'(hit_mask), 0);
    check("R1 status", 32'(status), 0);
    check("R1 exceptions", 32'({exc_fault, exc_trap}), 0);
    access(32'h0, 4'd1, 2'd0, 2'd0, 1'b0); // R1 control zero: slot 0 at 0 would match
    check("R1 no hit from cleared registers", 32'(hit), 0);

    // R10 load slot addresses
    wr(3'd0, 32'h00001000);
    wr(3'd1, 32'h00001002);
    wr(3'd2, 32'h00003005);
    wr(3'd3, 32'h00004007);

    for (int i = 0; i < NV; i++) begin
      wr(3'd4, TBL[i].ctl);
      access(TBL[i].addr, TBL[i].size, TBL[i].ta, TBL[i].tb, 1'b0);
      check($sformatf("R6 vector %0d hit (R2 R3 R4 R5)", i), 32'(hit), 32'(TBL[i].ehit));
      check($sformatf("R6 vector %0d mask (R2 R3 R4 R5)", i), 32'(hit_mask), 32'(TBL[i].emask));
    end

    // R7 idle cycle after an access
    @(negedge clk);
    check("R7 idle hit", 32'(hit), 0);
    check("R7 idle mask", 32'(hit_mask), 0);

    // R10 status clear by write
    wr(3'd5, 32'h0);
    check("R10 status cleared", 32'(status), 0);

    // R8 sticky accumulation, all slots enabled, lengths 00, type 0
    wr(3'd4, 32'h000000FF);
    access(32'h00001000, 4'd1, 2'd0, 2'd0, 1'b0);
    check("R8 fault pulse", 32'(exc_fault), 1);
    check("R8 status first", 32'(status), 32'h1);
    access(32'h00001002, 4'd1, 2'd0, 2'd0, 1'b0);
    check("R8 status accumulates", 32'(status), 32'h3);
    access(32'h00009999, 4'd1, 2'd0, 2'd0, 1'b0);
    check("R8 status held on miss", 32'(status), 32'h3);
    check("R8 no fault on miss", 32'(exc_fault), 0);
    wr(3'd5, 32'h0);
    check("R10 status cleared again", 32'(status), 0);

    // R9 deferral
    wr(3'd4, 32'h00000001);
    access(32'h00001000, 4'd1, 2'd0, 2'd0, 1'b1);
    check("R9 inhibited hit visible", 32'(hit), 1);
    check("R9 inhibited status unchanged", 32'(status), 0);
    check("R9 inhibited no exception", 32'({exc_fault, exc_trap}), 0);
    access(32'h00005000, 4'd1, 2'd0, 2'd0, 1'b0);
    check("R9 trap on next boundary", 32'(exc_trap), 1);
    check("R9 pending committed", 32'(status), 32'h1);
    check("R9 no fault on miss", 32'(exc_fault), 0);
    access(32'h00005000, 4'd1, 2'd0, 2'd0, 1'b0);
    check("R9 trap only once", 32'(exc_trap), 0);

    // R10 status write in same cycle as a committing access
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd5; cfg_wdata = 32'h4;
    acc_valid = 1'b1; acc_addr = 32'h00001000; acc_size = 4'd1;
    acc_type_a = 2'd0; acc_type_b = 2'd0; dbg_inhibit = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    check("R10 write ORed with commit", 32'(status), 32'h5);

    // R5 modulo wrap at top of address space
    wr(3'd2, 32'hFFFFFFFF);
    wr(3'd4, 32'h00000010);
    access(32'hFFFFFFFE, 4'd2, 2'd0, 2'd0, 1'b0);
    check("R5 top of space hit", 32'(hit_mask), 32'h4);
    access(32'hFFFFFFFF, 4'd2, 2'd0, 2'd0, 1'b0);
    check("R5 wrapped end misses", 32'(hit), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule